// File: doc/BRIEF.md
# Processor Cycle Counter with Control Register

This block holds a 32-bit cycle counter and the small control register that governs it. Both sit behind one register access port: an access strobe, a select that picks control or counter, a write flag, write data, combinational read data, and the privilege level of the requester. When enabled, the counter advances once per core clock. It can also be switched to advance once per 64 active cycles. A control write can clear the counter. Software can load the counter directly at any time.

The control register has four storable fields: enable at bit 0, divide at bit 3, a spare export bit at bit 4, and freeze at bit 5. Freeze stops the counter whenever it is set, because the counting region is always treated as one where non-invasive debug is prohibited. Bit 2 is a clear command that is acted on but never stored. Illegal accesses raise `undef_fault` during the access cycle and have no effect on state.

Top module: `cycle_count_ctrl`

## Requirements
- R1: After reset the control register reads 0 and the counter reads 0.
- R2: A permitted control write updates only bits 0, 3, 4 and 5 (mask 0x39). All other bits keep their value, so they read 0. Bit 2 always reads 0.
- R3: A permitted control write with bit 2 set clears the counter and the 64-cycle prescaler at that clock edge. The clear takes priority over an increment in the same cycle.
- R4: With bit 0 = 1, bit 5 = 0 and bit 3 = 0, the counter increments by one on every clock edge. The first increment is on the edge after the control write edge.
- R5: With bit 3 = 1, a 6-bit prescaler advances on each active cycle. The counter increments only on the cycle in which the prescaler wraps from 63 to 0, so it advances once per 64 active cycles.
- R6: While bit 0 = 0 or bit 5 = 1, the counter and the prescaler hold their values.
- R7: A permitted counter write loads the write data at that edge. The load wins over an increment in the same cycle. Counting continues from the loaded value if the counter is active.
- R8: A control write at privilege level 0 while `user_en` is 0 asserts `undef_fault` and leaves the control register and the counter unchanged. Control reads are allowed at any level.
- R9: Any counter access at privilege level 0 asserts `undef_fault`. Such a read returns 0, and such a write leaves the counter unchanged.
- R10: The counter wraps from 0xFFFFFFFF to 0 without any flag.
- R11: When not faulted, `acc_rdata` shows the current control register (`acc_sel` = 0) or the current counter (`acc_sel` = 1). `undef_fault` is 0 whenever `acc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_sel | input | 1 | 0 selects control register, 1 selects counter |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Privilege level of the requester, 0 is lowest |
| user_en | input | 1 | Permits control writes at level 0 |
| acc_rdata | output | 32 | Read data (combinational) |
| undef_fault | output | 1 | Access refused this cycle |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 6-bit prescaler and a 2-bit privilege level. The 6-bit prescaler keeps a full divide period at 64 cycles, so several prescaler wraps, and a C-bit clear in the middle of a period, fit into a few hundred cycles. The 32-bit width puts the wrap out of reach by counting, so the bench reaches it by loading the counter near all-ones and letting it run.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_COUNT = 1'b1
  } acc_sel_e;

  localparam int BIT_EN     = 0;
  localparam int BIT_CLR    = 2;
  localparam int BIT_DIV    = 3;
  localparam int BIT_FREEZE = 5;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_0039;
endpackage

// File: rtl/cyc_access_check.sv
module cyc_access_check #(
  parameter int PRIV_W = 2
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_sel,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              user_en,
  output logic              ctrl_wr_ok,
  output logic              cnt_wr_ok,
  output logic              fault
);
  import cyc_pkg::*;

  logic lowest;
  logic ctrl_wr_deny;
  logic cnt_deny;

  always_comb begin
    lowest       = (priv_lvl == '0);
    ctrl_wr_deny = acc_en & acc_wr & (acc_sel == SEL_CTRL) & lowest & ~user_en;
    cnt_deny     = acc_en & (acc_sel == SEL_COUNT) & lowest;
    ctrl_wr_ok   = acc_en & acc_wr & (acc_sel == SEL_CTRL) & ~ctrl_wr_deny;
    cnt_wr_ok    = acc_en & acc_wr & (acc_sel == SEL_COUNT) & ~cnt_deny;
    fault        = ctrl_wr_deny | cnt_deny;
  end
endmodule

// File: rtl/cyc_ctrl_reg.sv
module cyc_ctrl_reg #(
  parameter int          REG_W = 32,
  parameter logic [REG_W-1:0] WMASK = '0,
  parameter int          CLR_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic             clr_pulse
);
  logic [REG_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d    = (ctrl_q & ~WMASK) | (wdata & WMASK);
    clr_pulse = wr_ok & wdata[CLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ok) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic wrap
);
  logic [DIV_LOG2-1:0] pre_q;
  logic [DIV_LOG2-1:0] pre_d;
  logic                pre_ce;

  always_comb begin
    pre_ce = clr | run;
    pre_d  = clr ? '0 : pre_q + 1'b1;
    wrap   = run & ~clr & (pre_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = clr | load | inc;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cycle_count_ctrl.sv
module cycle_count_ctrl #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6,
  parameter int PRIV_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [CNT_W-1:0]  acc_wdata,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              user_en,
  output logic [CNT_W-1:0]  acc_rdata,
  output logic              undef_fault
);
  import cyc_pkg::*;

  localparam logic [CNT_W-1:0] WMASK = CNT_W'(CTRL_WMASK);

  logic             ctrl_wr_ok;
  logic             cnt_wr_ok;
  logic             fault;
  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clr_pulse;
  logic             active;
  logic             wrap;
  logic             inc;

  cyc_access_check #(.PRIV_W(PRIV_W)) u_acc (
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .priv_lvl  (priv_lvl),
    .user_en   (user_en),
    .ctrl_wr_ok(ctrl_wr_ok),
    .cnt_wr_ok (cnt_wr_ok),
    .fault     (fault)
  );

  cyc_ctrl_reg #(.REG_W(CNT_W), .WMASK(WMASK), .CLR_BIT(BIT_CLR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (ctrl_wr_ok),
    .wdata    (acc_wdata),
    .ctrl_q   (ctrl_q),
    .clr_pulse(clr_pulse)
  );

  always_comb begin
    active = ctrl_q[BIT_EN] & ~ctrl_q[BIT_FREEZE];
  end

  cyc_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_pulse),
    .run  (active),
    .wrap (wrap)
  );

  always_comb begin
    inc = active & (ctrl_q[BIT_DIV] ? wrap : 1'b1);
  end

  cyc_count_core #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_pulse),
    .load    (cnt_wr_ok),
    .load_val(acc_wdata),
    .inc     (inc),
    .cnt_q   (cnt_q)
  );

  always_comb begin
    undef_fault = fault;
    if (fault)                     acc_rdata = '0;
    else if (acc_sel == SEL_COUNT) acc_rdata = cnt_q;
    else                           acc_rdata = ctrl_q;
  end
endmodule

// File: rtl/cycle_count_ctrl_chk.sv
module cycle_count_ctrl_chk #(
  parameter int CNT_W  = 32,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_sel,
  input logic              acc_wr,
  input logic [CNT_W-1:0]  acc_wdata,
  input logic [PRIV_W-1:0] priv_lvl,
  input logic              user_en,
  input logic [CNT_W-1:0]  acc_rdata,
  input logic              undef_fault,
  input logic [CNT_W-1:0]  ctrl_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] MSK = CNT_W'(cyc_pkg::CTRL_WMASK);

  logic c_wr, c_wr_bad, k_wr, run, clr;
  always_comb begin
    c_wr     = acc_en & acc_wr & ~acc_sel & ((priv_lvl != '0) | user_en);
    c_wr_bad = acc_en & acc_wr & ~acc_sel & (priv_lvl == '0) & ~user_en;
    k_wr     = acc_en & acc_wr & acc_sel & (priv_lvl != '0);
    run      = ctrl_q[0] & ~ctrl_q[5];
    clr      = c_wr & acc_wdata[2];
  end

  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> ctrl_q == (($past(acc_wdata) & MSK) | ($past(ctrl_q) & ~MSK)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl_q[3] && !clr && !k_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_div_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_q[3] && !clr && !k_wr) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !k_wr) |=> $stable(cnt_q));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    k_wr |=> cnt_q == $past(acc_wdata));

  assert_ctrl_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_bad |-> undef_fault ##1 $stable(ctrl_q));

  assert_cnt_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_sel && priv_lvl == '0) |-> (undef_fault && acc_rdata == '0));

  assert_idle_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> !undef_fault);
endmodule

bind cycle_count_ctrl cycle_count_ctrl_chk #(.CNT_W(CNT_W), .PRIV_W(PRIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_sel    (acc_sel),
  .acc_wr     (acc_wr),
  .acc_wdata  (acc_wdata),
  .priv_lvl   (priv_lvl),
  .user_en    (user_en),
  .acc_rdata  (acc_rdata),
  .undef_fault(undef_fault),
  .ctrl_q     (ctrl_q),
  .cnt_q      (cnt_q)
);

// File: tb/cycle_count_ctrl_bench.sv
`timescale 1ns/1ps
module cycle_count_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_sel, acc_wr, user_en;
  logic [31:0] acc_wdata;
  logic [1:0]  priv_lvl;
  logic [31:0] acc_rdata;
  logic        undef_fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_ctrl, m_cnt;
  logic [5:0]  m_pre;

  always #2 clk = ~clk;

  cycle_count_ctrl u_cycle_count_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .priv_lvl(priv_lvl),
    .user_en(user_en), .acc_rdata(acc_rdata), .undef_fault(undef_fault)
  );

  function automatic logic f_fault(logic en, logic sel, logic wr, logic [1:0] pv, logic ue);
    // R8 control write at level 0 needs user_en; R9 counter needs level >= 1
    return en && ((sel && pv == 2'd0) || (!sel && wr && pv == 2'd0 && !ue));
  endfunction

  function automatic logic [31:0] f_rdata(logic flt, logic sel);
    if (flt) return 32'h0;
    return sel ? m_cnt : m_ctrl;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic en, logic sel, logic wr, logic [31:0] wd,
                      logic [1:0] pv, logic ue, string req);
    logic flt, run, clr, cwr, kwr;
    @(negedge clk);
    acc_en = en; acc_sel = sel; acc_wr = wr; acc_wdata = wd;
    priv_lvl = pv; user_en = ue;
    #1;
    flt = f_fault(en, sel, wr, pv, ue);
    if (en) begin
      chk(req, {31'b0, undef_fault}, {31'b0, flt});
      chk(req, acc_rdata, f_rdata(flt, sel));
    end
    @(posedge clk);
    cwr = en && wr && !sel && !flt;
    kwr = en && wr && sel && !flt;
    clr = cwr && wd[2];
    run = m_ctrl[0] && !m_ctrl[5];
    if (clr)               m_cnt = 32'h0;
    else if (kwr)          m_cnt = wd;
    else if (run && (!m_ctrl[3] || m_pre == 6'd63)) m_cnt = m_cnt + 32'd1;
    if (clr)      m_pre = 6'd0;
    else if (run) m_pre = m_pre + 6'd1;
    if (cwr) m_ctrl = (m_ctrl & ~32'h39) | (wd & 32'h39);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 1'b0, "R11");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c5a7));
    rst_n = 1'b0; acc_en = 1'b0; acc_sel = 1'b0; acc_wr = 1'b0;
    acc_wdata = 32'h0; priv_lvl = 2'd0; user_en = 1'b0;
    m_ctrl = 32'h0; m_cnt = 32'h0; m_pre = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step(1'b1, 1'b0, 1'b0, 32'h0, 2'd1, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R1");
    chk("R1", m_cnt, 32'h0);

    step(1'b1, 1'b0, 1'b1, 32'h1, 2'd0, 1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0, "R8");

    step(1'b1, 1'b0, 1'b1, 32'h1, 2'd1, 1'b0, "R4");
    idle(9);
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd2, 1'b0, "R4");
    chk("R4", m_cnt, 32'd10);

    step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFB, 2'd3, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, 32'h0, 2'd0, 1'b0, "R2");
    chk("R2", m_ctrl, 32'h39);
    idle(5);
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R6");

    step(1'b1, 1'b0, 1'b1, 32'h0000_0009, 2'd0, 1'b1, "R5");
    idle(130);
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R5");

    step(1'b1, 1'b0, 1'b1, 32'h0000_000D, 2'd1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R3");
    chk("R3", m_cnt, 32'h0);

    step(1'b1, 1'b0, 1'b1, 32'h1, 2'd1, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFE, 2'd1, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R7");
    idle(2);
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R10");
    chk("R10", m_cnt, 32'd2);

    step(1'b1, 1'b1, 1'b1, 32'h1234_5678, 2'd0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd3, 1'b0, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      logic        sel, wr;
      wd  = $urandom;
      sel = $urandom_range(1, 0);
      wr  = ($urandom_range(3, 0) == 0);
      if ($urandom_range(3, 0) != 0) wd[5] = 1'b0;
      if ($urandom_range(7, 0) != 0) wd[2] = 1'b0;
      if ($urandom_range(15, 0) < 9)
        step(1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 1'b0, "R11");
      else
        step(1'b1, sel, wr, wd, 2'($urandom_range(3, 0)),
             1'($urandom_range(1, 0)), "R11");
    end

    step(1'b1, 1'b1, 1'b0, 32'h0, 2'd1, 1'b0, "R11");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule